// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave end of a serial nonvolatile memory reached over SPI in mode 0. Each access starts when chip select falls. The master then shifts in an 8-bit opcode, MSB first, on the rising edges of SCK. Depending on the opcode, a 16-bit address, data bytes or a status byte follow. Read data and the status byte leave on the serial output MSB first, and each bit changes on a falling SCK edge. The serial output is driven only while the block is answering.

Memory and status writes are protected in three ways:
- A write enable latch must be set first.
- A write takes effect only when chip select rises exactly on a byte boundary after at least one data byte.
- The nonvolatile programming is modelled as a busy period of fixed length. During it the write-in-progress flag reads 1.

Page writes collect bytes into a page buffer. The index in that buffer wraps inside the 32-byte page. The buffer is copied into the on-chip array when the busy period ends.

All SPI pins are sampled with the system clock, so SCK must stay at each level for several system clocks. The FSM has nine states:
- IDLE: chip select high, or no falling edge seen yet.
- CMD: taking the opcode.
- ADDR: taking the 16-bit address.
- RDATA: streaming array bytes out.
- STAT: streaming the status byte out.
- WDATA: collecting write bytes.
- SRDATA: taking the status data byte.
- SRDONE: status byte complete and waiting for chip select to rise.
- SKIP: ignoring SCK until chip select rises.

The transitions are:
- IDLE goes to CMD on a chip select fall.
- CMD goes to STAT on opcode 0x05.
- CMD goes to ADDR on opcode 0x03 (when not busy) or 0x02 (when not busy and the latch is set).
- CMD goes to SRDATA on opcode 0x01 (when not busy and the latch is set).
- CMD goes to SKIP on any other opcode.
- ADDR goes to RDATA or WDATA after 16 address bits.
- SRDATA goes to SRDONE after 8 bits.
- SRDONE goes to SKIP on any further SCK rise.
- Every state returns to IDLE when chip select is high.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, so_drv is 0, the write enable latch and the write-in-progress flag are 0, the six upper status bits are 0, and every array byte reads 0xFF.
- R2: A falling edge on cs_n is needed to accept an opcode. If cs_n is already low when reset ends, SCK activity does not drive the output until cs_n has gone high and low again. Input bits are taken on rising SCK edges, and so_dat changes only on falling edges.
- R3: Opcode 0x03 followed by a 16-bit address (MSB first) returns array bytes MSB first from that address. The address then increments across page boundaries and wraps at the end of the array.
- R4: Opcode 0x05 returns the status byte, with bit 0 as write-in-progress, bit 1 as the write enable latch and bits 7:2 as the stored user bits. The byte repeats for as long as SCK runs.
- R5: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it.
- R6: Opcodes 0x02 and 0x01 sent while the latch is clear change neither the array nor the status byte, and they start no busy period.
- R7: A write (0x02) is committed only if cs_n rises with zero bits of a new byte after at least one complete data byte. A rise at any other point leaves the array unchanged, starts no busy period and clears the latch.
- R8: Write bytes land at the address given, with the index wrapping inside its 32-byte page. Bytes in other pages are not touched.
- R9: Opcode 0x01 takes exactly one byte. Bits 7:2 of that byte become the user bits, and bits 1:0 are discarded. Extra SCK edges before cs_n rises abort the write and clear the latch.
- R10: After a commit, write-in-progress and the latch both read 1 for WR_CYCLES clocks. Both then clear together and the new data becomes visible.
- R11: While busy, opcodes 0x03, 0x02, 0x01, 0x06 and 0x04 are ignored, and so_drv stays 0 for them. Opcode 0x05 still answers.
- R12: so_drv is 0 whenever cs_n is high. Unknown opcodes leave so_drv at 0 and change no state until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 (idles low) |
| si | input | 1 | Serial data into the block |
| so_dat | output | 1 | Serial data out, valid while so_drv is 1 |
| so_drv | output | 1 | Output enable for the serial data pin; 0 means high impedance |

## Verification
The directed tasks target the following boundaries:
- Chip select rising three bits into a byte, or straight after the address. A design that counted bits loosely would commit a partial write, or forget to clear the latch.
- A page write that starts two bytes before the end of a page. A design without the page wrap would spill into the next page instead of returning to the page start.
- A read across the top of the array. A design that did not wrap the pointer would return garbage there.
- A chip select held low through reset, and commands sent while the write cycle runs. A design that missed the falling-edge rule or the busy lockout would answer on the output or drop the latch.
- A status write carrying 1s in its two low bits. A design that stored those bits would show a false busy flag or a false latch.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_STAT,
        ST_SRDATA,
        ST_SRDONE,
        ST_SKIP
    } ee_state_e;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    localparam int ADDR_BITS = 16;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_act,
    output logic si_s
);

    logic sck_s, sck_d, cs_s, cs_d;

    // Chip select stages reset low so that a select already held low at
    // reset release produces no falling edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s <= 1'b0;
            sck_d <= 1'b0;
            cs_s  <= 1'b0;
            cs_d  <= 1'b0;
            si_s  <= 1'b0;
        end else begin
            sck_s <= sck;
            sck_d <= sck_s;
            cs_s  <= cs_n;
            cs_d  <= cs_s;
            si_s  <= si;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign cs_rise  = cs_s & ~cs_d;
    assign cs_act   = ~cs_s;

endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int DEPTH = 256,
    parameter int PAGE  = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               buf_clr,
    input  logic                               buf_we,
    input  logic [$clog2(PAGE)-1:0]            buf_idx,
    input  logic [7:0]                         buf_din,
    input  logic                               commit,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_sel,
    input  logic [$clog2(DEPTH)-1:0]           rd_addr,
    output logic [7:0]                         rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pmask;

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pmask <= '0;
        else if (buf_clr) pmask <= '0;
        else if (buf_we)  pmask[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (pmask[i]) mem[{page_sel, PW'(i)}] <= pbuf[i];
        end
    end

    logic unused_aw;
    assign unused_aw = (AW > PW);

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_ee_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so_dat,
    output logic so_drv
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    ee_state_e state, nxt;

    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, si_s;
    logic busy, done;
    logic [7:0] rd_data;

    logic [3:0]           cnt;
    logic [14:0]          sh_in;
    logic [ADDR_BITS-1:0] ptr;
    logic                 is_wr, armed, wel, bytes_seen, pend_sr, so_q;
    logic [5:0]           sr_user, sr_pend;
    logic [AW-PW-1:0]     page_q;
    logic [7:0]           out_sh;

    logic [7:0]           in_byte;
    logic [ADDR_BITS-1:0] in_addr;
    logic [7:0]           status_byte;
    logic                 byte_done, addr_done;
    logic                 wr_ok, commit_wr, commit_sr, start_wr, abort_wr;
    logic                 buf_clr, buf_we;
    logic [AW-1:0]        rd_addr;

    spi_ee_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .cs_act(cs_act), .si_s(si_s)
    );

    spi_ee_busy #(.CYCLES(WR_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start_wr), .busy(busy), .done(done)
    );

    spi_ee_array #(.DEPTH(MEM_BYTES), .PAGE(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(ptr[PW-1:0]), .buf_din(in_byte), .commit(done && !pend_sr),
        .page_sel(page_q), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign in_byte     = {sh_in[6:0], si_s};
    assign in_addr     = {sh_in, si_s};
    assign status_byte = {sr_user, wel, busy};
    assign byte_done   = sck_rise && (cnt[2:0] == 3'd7);
    assign addr_done   = sck_rise && (cnt == 4'd15);
    assign wr_ok       = !busy && wel;
    assign commit_wr   = cs_rise && (state == ST_WDATA) && (cnt == 4'd0) && bytes_seen;
    assign commit_sr   = cs_rise && (state == ST_SRDONE);
    assign start_wr    = commit_wr || commit_sr;
    assign abort_wr    = cs_rise && armed && !start_wr;
    assign buf_clr     = (state == ST_CMD) && byte_done && (in_byte == OP_WRITE) && wr_ok;
    assign buf_we      = (state == ST_WDATA) && byte_done;
    assign rd_addr     = (state == ST_ADDR) ? in_addr[AW-1:0] : ptr[AW-1:0];
    assign so_drv      = cs_act && ((state == ST_RDATA) || (state == ST_STAT));
    assign so_dat      = so_drv ? so_q : 1'b0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) nxt = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        if (in_byte == OP_RDSR)                  nxt = ST_STAT;
                        else if (in_byte == OP_READ && !busy)    nxt = ST_ADDR;
                        else if (in_byte == OP_WRITE && wr_ok)   nxt = ST_ADDR;
                        else if (in_byte == OP_WRSR && wr_ok)    nxt = ST_SRDATA;
                        else                                     nxt = ST_SKIP;
                    end
                end
                ST_ADDR:   if (addr_done) nxt = is_wr ? ST_WDATA : ST_RDATA;
                ST_SRDATA: if (byte_done) nxt = ST_SRDONE;
                ST_SRDONE: if (sck_rise)  nxt = ST_SKIP;
                ST_RDATA, ST_WDATA, ST_STAT, ST_SKIP: nxt = state;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            sh_in      <= '0;
            ptr        <= '0;
            is_wr      <= 1'b0;
            armed      <= 1'b0;
            wel        <= 1'b0;
            bytes_seen <= 1'b0;
            pend_sr    <= 1'b0;
            sr_user    <= '0;
            sr_pend    <= '0;
            page_q     <= '0;
            out_sh     <= '0;
            so_q       <= 1'b0;
        end else begin
            if (cs_act && sck_rise) sh_in <= {sh_in[13:0], si_s};

            if (nxt != state)   cnt <= '0;
            else if (sck_rise)  cnt <= (state == ST_ADDR) ? cnt + 4'd1
                                                          : {1'b0, cnt[2:0] + 3'd1};

            unique case (state)
                ST_CMD: if (byte_done) begin
                    is_wr <= (in_byte == OP_WRITE);
                    if (in_byte == OP_WREN && !busy) wel <= 1'b1;
                    if (in_byte == OP_WRDI && !busy) wel <= 1'b0;
                    if ((in_byte == OP_WRITE || in_byte == OP_WRSR) && wr_ok) armed <= 1'b1;
                    if (in_byte == OP_RDSR) out_sh <= status_byte;
                end
                ST_ADDR: if (addr_done) begin
                    if (is_wr) begin
                        ptr    <= in_addr;
                        page_q <= in_addr[AW-1:PW];
                    end else begin
                        ptr    <= in_addr + 1'b1;
                        out_sh <= rd_data;
                    end
                end
                ST_RDATA: if (byte_done) begin
                    out_sh <= rd_data;
                    ptr    <= ptr + 1'b1;
                end
                ST_STAT:   if (byte_done) out_sh <= status_byte;
                ST_WDATA: if (byte_done) begin
                    ptr        <= {ptr[ADDR_BITS-1:PW], ptr[PW-1:0] + 1'b1};
                    bytes_seen <= 1'b1;
                end
                ST_SRDATA: if (byte_done) sr_pend <= in_byte[7:2];
                ST_IDLE, ST_SRDONE, ST_SKIP: ;
                default: ;
            endcase

            if (sck_fall && cs_act && (state == ST_RDATA || state == ST_STAT)) begin
                so_q   <= out_sh[7];
                out_sh <= {out_sh[6:0], 1'b0};
            end

            if (cs_rise) begin
                armed      <= 1'b0;
                bytes_seen <= 1'b0;
                if (commit_sr) pend_sr <= 1'b1;
                if (commit_wr) pend_sr <= 1'b0;
                if (abort_wr)  wel     <= 1'b0;
            end

            if (done) begin
                wel <= 1'b0;
                if (pend_sr) sr_user <= sr_pend;
            end
        end
    end

endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker
    import spi_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      so_drv,
    input logic      so_dat,
    input logic      busy,
    input logic      wel,
    input logic      sck_fall,
    input ee_state_e state
);

    // R12: output released whenever select has been high for two samples
    p_hiz_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so_drv);

    // R2: driven data only moves after a falling SCK edge
    p_so_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (so_drv && $past(so_drv) && !$past(sck_fall)) |-> $stable(so_dat));

    // R6: a busy period can only begin with the latch set
    p_wel_needed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);

    // R10: latch is clear once the write cycle ends
    p_wel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R11: no address or data phase while programming
    p_busy_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(state inside {ST_ADDR, ST_RDATA, ST_WDATA, ST_SRDATA, ST_SRDONE}));

endmodule

bind spi_eeprom_slave spi_ee_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_drv(so_drv), .so_dat(so_dat),
    .busy(busy), .wel(wel), .sck_fall(sck_fall), .state(state)
);

// File: tb/sim_spi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_spi_eeprom_slave;

    localparam int WRC  = 1000;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so_dat, so_drv;

    int errors = 0;
    int checks = 0;
    logic drv_any;

    always #2 clk = ~clk;

    spi_eeprom_slave #(.MEM_BYTES(256), .PAGE_BYTES(32), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so_dat(so_dat), .so_drv(so_drv)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic xbits(input int n, input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - n; b--) begin
            si = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = so_dat;
            drv_any |= so_drv;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(8, tx, rx);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        drv_any = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, v); desel();
    endtask

    task automatic rd1(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v); desel();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                      input logic [7:0] d2, input int n);
        logic [7:0] d;
        sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
        xfer(d0, d);
        if (n > 1) xfer(d1, d);
        if (n > 2) xfer(d2, d);
        desel();
    endtask

    task automatic wait_wr();
        repeat (WRC + 20) @(negedge clk);
    endtask

    task automatic t_power_cs();
        logic [7:0] v, d;
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 so_drv after reset", {7'b0, so_drv}, 8'h00);
        drv_any = 1'b0;
        xfer(8'h05, d); xfer(8'h00, d);
        chk("R2 no answer without select fall", {7'b0, drv_any}, 8'h00);
        desel();
        chk("R12 released while deselected", {7'b0, so_drv}, 8'h00);
        rdsr(v);
        chk("R1 status after reset", v, 8'h00);
        rd1(16'h0000, v);
        chk("R1 erased array", v, 8'hFF);
    endtask

    task automatic t_wel();
        logic [7:0] v, d;
        op1(8'h06);
        sel(); xfer(8'h05, d); xfer(8'h00, v); xfer(8'h00, d); desel();
        chk("R5 latch set", v, 8'h02);
        chk("R4 status repeats", d, 8'h02);
        op1(8'h04);
        rdsr(v);
        chk("R5 latch cleared", v, 8'h00);
    endtask

    task automatic t_nowel();
        logic [7:0] v, d;
        wr(16'h0010, 8'h55, 8'h00, 8'h00, 1);
        rdsr(v);
        chk("R6 no busy without latch", v, 8'h00);
        rd1(16'h0010, v);
        chk("R6 array untouched", v, 8'hFF);
        sel(); xfer(8'h01, d); xfer(8'hF0, d); desel();
        rdsr(v);
        chk("R6 status untouched", v, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] v;
        op1(8'h06);
        wr(16'h003E, 8'hA1, 8'hA2, 8'hA3, 3);
        rdsr(v);
        chk("R10 busy and latch during cycle", v, 8'h03);
        wait_wr();
        rdsr(v);
        chk("R10 both clear after cycle", v, 8'h00);
        rd1(16'h003E, v); chk("R8 first byte", v, 8'hA1);
        rd1(16'h003F, v); chk("R8 page end byte", v, 8'hA2);
        rd1(16'h0020, v); chk("R8 wrapped to page start", v, 8'hA3);
        rd1(16'h0040, v); chk("R8 next page untouched", v, 8'hFF);
    endtask

    task automatic t_read_wrap();
        logic [7:0] v, w, d;
        op1(8'h06); wr(16'h00FF, 8'h5A, 8'h00, 8'h00, 1); wait_wr();
        op1(8'h06); wr(16'h0000, 8'hC3, 8'h00, 8'h00, 1); wait_wr();
        sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'hFF, d); xfer(8'h00, v); xfer(8'h00, w); desel();
        chk("R3 last array byte", v, 8'h5A);
        chk("R3 wrap to address 0", w, 8'hC3);
        sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h3F, d); xfer(8'h00, v); xfer(8'h00, w); desel();
        chk("R3 sequential byte", v, 8'hA2);
        chk("R3 crosses page boundary", w, 8'hFF);
    endtask

    task automatic t_abort();
        logic [7:0] v, d;
        op1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h11, d); xbits(3, 8'hE0, d); desel();
        rdsr(v);
        chk("R7 mid-byte abort: no busy, latch cleared", v, 8'h00);
        rd1(16'h0050, v);
        chk("R7 array unchanged after abort", v, 8'hFF);
        op1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); desel();
        rdsr(v);
        chk("R7 abort with no data byte", v, 8'h00);
    endtask

    task automatic t_wrsr();
        logic [7:0] v, d;
        op1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
        rdsr(v);
        chk("R9 status write in progress", v, 8'h03);
        wait_wr();
        rdsr(v);
        chk("R9 low bits discarded", v, 8'hFC);
        op1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h00, d); xbits(2, 8'h00, d); desel();
        rdsr(v);
        chk("R9 extra clocks abort status write", v, 8'hFC);
        op1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
        wait_wr();
        rdsr(v);
        chk("R9 user bits rewritten", v, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] v, d;
        op1(8'h06);
        wr(16'h0060, 8'h77, 8'h00, 8'h00, 1);
        sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h60, d); xfer(8'h00, d); desel();
        chk("R11 read ignored while busy", {7'b0, drv_any}, 8'h00);
        op1(8'h04);
        rdsr(v);
        chk("R11 disable ignored while busy", v, 8'h03);
        wait_wr();
        rdsr(v);
        chk("R10 cycle finished", v, 8'h00);
        rd1(16'h0060, v);
        chk("R10 data visible after cycle", v, 8'h77);
    endtask

    task automatic t_unknown();
        logic [7:0] v, d;
        op1(8'h06);
        sel(); xfer(8'hAB, d); xfer(8'h12, d); xfer(8'h34, d);
        chk("R12 unknown opcode not answered", {7'b0, drv_any}, 8'h00);
        desel();
        rdsr(v);
        chk("R12 unknown opcode changes nothing", v, 8'h02);
        op1(8'h04);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drv_any = 1'b0;
        t_power_cs();
        t_wel();
        t_nowel();
        t_page();
        t_read_wrap();
        t_abort();
        t_wrsr();
        t_busy();
        t_unknown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule